// File: doc/BRIEF.md
# DRAM Rank Power-Down Idle Controller

This block decides when the ranks on one DRAM channel drop their clock enable (CKE) to enter power-down, and when they come back out. Each rank has a counter of idle cycles. The counter is compared against a programmable threshold, and a rank that stays idle for that many DRAM clock cycles enters power-down. The first command addressed to a sleeping rank brings it back up.

A configuration word has three fields. The first picks the power-down flavour: active, precharge, DLL-off, or one of two combined flavours that depend on whether a page is open. The second sets the idle threshold. The third chooses between one shared decision for the whole channel and an independent decision for each rank. For every rank that is asleep, the block reports which flavour was used, so that exit latency can be applied downstream. It also raises a wake-ready signal while every rank has CKE high.

A new configuration is held in a pending register. It takes effect only once every rank is awake, and all idle counters restart when it is applied.

Top module: `rank_pdwn_ctrl`

## Requirements
- R1: After reset all CKE outputs are high, every type field reads 0, wake-ready is high, the error flag is low, and power-down is disabled (mode 0, threshold 0).
- R2: With a legal non-zero mode and threshold N>0, a rank that receives no command for N consecutive clock edges after its counter was cleared has CKE low after the Nth edge.
- R3: A command strobe to a rank clears that rank's idle counter and returns its CKE high after the edge that samples the strobe.
- R4: With the global bit at 1, a command to any rank clears the shared idle count, and all ranks enter and leave power-down together. For the combined modes, the page-open condition in this case is "any rank has an open page".
- R5: Mode 0, or a threshold of 0, never takes a rank into power-down.
- R6: Each rank's 2-bit type field (rank r at bits 2r+1:2r) reads 0 while awake, 1 for active power-down, 2 for precharge power-down and 3 for DLL-off power-down. Mode code 1 gives 1, code 2 gives 2, and code 6 gives 3.
- R7: In mode code 3, a rank enters with type 1 if its page is open at entry and type 2 otherwise. Mode code 7 does the same with 3 in place of 2. The type is held until the rank wakes.
- R8: Mode codes 4, 5 and 8 to 15 are reserved. Applying one disables power-down and sets an error flag that stays high until reset.
- R9: A configuration write is captured at the write edge. It is applied at the first later edge at which all ranks are awake, and that edge clears every idle counter.
- R10: Wake-ready is high exactly when every rank has CKE high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DRAM controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | NUM_RANKS | Command issued to rank r this cycle |
| page_open_i | input | NUM_RANKS | Rank r has at least one open page |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_global_i | input | 1 | 1: channel-wide decision, 0: per rank |
| cfg_mode_i | input | 4 | Power-down flavour code |
| cfg_idle_i | input | IDLE_W | Idle threshold in clock cycles |
| cke_o | output | NUM_RANKS | Per-rank clock enable |
| pd_type_o | output | 2*NUM_RANKS | Per-rank power-down type |
| wake_ready_o | output | 1 | All ranks awake |
| cfg_err_o | output | 1 | Sticky reserved-mode flag |

## Verification
The outputs are all registered state, so a command or an idle edge changes CKE, the type field and wake-ready right after the edge that samples it. A configuration write shows up one edge later than that, at the apply edge. The bench drives inputs at the falling edge and steps a reference model right after each rising edge. It compares every output at the next falling edge, so each result is checked in the cycle it becomes due. The directed checks count edges from the apply edge: a threshold of N means CKE must still be high after N-1 idle edges and low after N.

// File: rtl/pdwn_pkg.sv
package pdwn_pkg;
  typedef enum logic [1:0] {
    PD_NONE   = 2'd0,
    PD_ACTIVE = 2'd1,
    PD_PRECH  = 2'd2,
    PD_DLL    = 2'd3
  } pd_type_e;

  localparam logic [3:0] MODE_OFF     = 4'h0;
  localparam logic [3:0] MODE_APD     = 4'h1;
  localparam logic [3:0] MODE_PPD     = 4'h2;
  localparam logic [3:0] MODE_APD_PPD = 4'h3;
  localparam logic [3:0] MODE_DLL     = 4'h6;
  localparam logic [3:0] MODE_APD_DLL = 4'h7;

  // 1 for codes that enable a power-down flavour
  function automatic logic mode_active(input logic [3:0] m);
    return (m == MODE_APD) || (m == MODE_PPD) || (m == MODE_APD_PPD) ||
           (m == MODE_DLL) || (m == MODE_APD_DLL);
  endfunction

  function automatic logic mode_reserved(input logic [3:0] m);
    return (m != MODE_OFF) && !mode_active(m);
  endfunction

  function automatic pd_type_e entry_type(input logic [3:0] m, input logic open);
    pd_type_e t;
    case (m)
      MODE_APD:     t = PD_ACTIVE;
      MODE_PPD:     t = PD_PRECH;
      MODE_APD_PPD: t = open ? PD_ACTIVE : PD_PRECH;
      MODE_DLL:     t = PD_DLL;
      MODE_APD_DLL: t = open ? PD_ACTIVE : PD_DLL;
      default:      t = PD_NONE;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/pdwn_cfg.sv
module pdwn_cfg
  import pdwn_pkg::*;
#(
  parameter int IDLE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              global_i,
  input  logic [3:0]        mode_i,
  input  logic [IDLE_W-1:0] idle_i,
  input  logic              all_awake_i,
  output logic              apply_o,
  output logic              global_o,
  output logic [3:0]        mode_o,
  output logic [IDLE_W-1:0] idle_o,
  output logic              pd_en_o,
  output logic              err_o
);
  logic              pend_v_q, pend_glob_q, glob_q, err_q;
  logic [3:0]        pend_mode_q, mode_q;
  logic [IDLE_W-1:0] pend_idle_q, idle_q;

  assign apply_o = pend_v_q && all_awake_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q    <= 1'b0;
      pend_glob_q <= 1'b0;
      pend_mode_q <= MODE_OFF;
      pend_idle_q <= '0;
    end else if (we_i) begin
      pend_v_q    <= 1'b1;
      pend_glob_q <= global_i;
      pend_mode_q <= mode_i;
      pend_idle_q <= idle_i;
    end else if (apply_o) begin
      pend_v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glob_q <= 1'b0;
      mode_q <= MODE_OFF;
      idle_q <= '0;
      err_q  <= 1'b0;
    end else if (apply_o) begin
      glob_q <= pend_glob_q;
      mode_q <= pend_mode_q;
      idle_q <= pend_idle_q;
      if (mode_reserved(pend_mode_q)) err_q <= 1'b1;
    end
  end

  assign global_o = glob_q;
  assign mode_o   = mode_q;
  assign idle_o   = idle_q;
  assign pd_en_o  = mode_active(mode_q) && (idle_q != '0);
  assign err_o    = err_q;

  p_hold_cfg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_awake_i |=> ($stable(mode_q) && $stable(idle_q) && $stable(glob_q)));

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
endmodule

// File: rtl/pdwn_rank.sv
module pdwn_rank
  import pdwn_pkg::*;
#(
  parameter int IDLE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              pd_en_i,
  input  logic [IDLE_W-1:0] idle_i,
  input  logic [3:0]        mode_i,
  input  logic              page_open_i,
  output logic              cke_o,
  output pd_type_e          type_o
);
  logic [IDLE_W-1:0] cnt_q;
  pd_type_e          type_q;
  logic              enter;

  assign enter = !clr_i && pd_en_i && (type_q == PD_NONE) &&
                 (cnt_q == idle_i - IDLE_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (pd_en_i && cnt_q < idle_i)  cnt_q <= cnt_q + IDLE_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     type_q <= PD_NONE;
    else if (clr_i)  type_q <= PD_NONE;
    else if (enter)  type_q <= entry_type(mode_i, page_open_i);
  end

  assign cke_o  = (type_q == PD_NONE);
  assign type_o = type_q;

  p_wake_on_cmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cke_o);

  p_disabled_no_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_en_i && cke_o) |=> cke_o);

  p_entry_after_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> ($past(cnt_q) == $past(idle_i) - IDLE_W'(1)));
endmodule

// File: rtl/rank_pdwn_ctrl.sv
module rank_pdwn_ctrl
  import pdwn_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int IDLE_W    = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_RANKS-1:0]   cmd_valid_i,
  input  logic [NUM_RANKS-1:0]   page_open_i,
  input  logic                   cfg_we_i,
  input  logic                   cfg_global_i,
  input  logic [3:0]             cfg_mode_i,
  input  logic [IDLE_W-1:0]      cfg_idle_i,
  output logic [NUM_RANKS-1:0]   cke_o,
  output logic [2*NUM_RANKS-1:0] pd_type_o,
  output logic                   wake_ready_o,
  output logic                   cfg_err_o
);
  logic              apply, glob, pd_en, any_cmd, any_open;
  logic [3:0]        mode;
  logic [IDLE_W-1:0] idle;

  assign any_cmd      = |cmd_valid_i;
  assign any_open     = |page_open_i;
  assign wake_ready_o = &cke_o;

  pdwn_cfg #(.IDLE_W(IDLE_W)) i_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .global_i    (cfg_global_i),
    .mode_i      (cfg_mode_i),
    .idle_i      (cfg_idle_i),
    .all_awake_i (&cke_o),
    .apply_o     (apply),
    .global_o    (glob),
    .mode_o      (mode),
    .idle_o      (idle),
    .pd_en_o     (pd_en),
    .err_o       (cfg_err_o)
  );

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    pd_type_e rank_type;
    logic     clr, open;

    // global mode shares one decision: every rank sees the same clear
    assign clr  = apply || (glob ? any_cmd : cmd_valid_i[r]);
    assign open = glob ? any_open : page_open_i[r];

    pdwn_rank #(.IDLE_W(IDLE_W)) i_rank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (clr),
      .pd_en_i     (pd_en),
      .idle_i      (idle),
      .mode_i      (mode),
      .page_open_i (open),
      .cke_o       (cke_o[r]),
      .type_o      (rank_type)
    );
    assign pd_type_o[2*r +: 2] = rank_type;
  end

  p_global_lockstep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glob |-> ((&cke_o) || !(|cke_o)));

  p_cmd_wakes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmd_valid_i) |=> (|cke_o));
endmodule

// File: tb/test_rank_pdwn_ctrl.sv
`timescale 1ns/1ps
module test_rank_pdwn_ctrl;
  localparam int NR = 4;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] cmd = '0, open = '0;
  logic          we = 1'b0, glob_in = 1'b0;
  logic [3:0]    mode_in = '0;
  logic [IW-1:0] idle_in = '0;
  logic [NR-1:0]   cke;
  logic [2*NR-1:0] ptype;
  logic            wready, err;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference model state
  int         m_cnt[NR];
  logic [1:0] m_type[NR];
  logic       m_glob, m_err, p_v, p_glob;
  logic [3:0] m_mode, p_mode;
  int         m_idle, p_idle;

  always #4 clk = ~clk;

  rank_pdwn_ctrl #(.NUM_RANKS(NR), .IDLE_W(IW)) i_rank_pdwn_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd), .page_open_i(open),
    .cfg_we_i(we), .cfg_global_i(glob_in), .cfg_mode_i(mode_in),
    .cfg_idle_i(idle_in), .cke_o(cke), .pd_type_o(ptype),
    .wake_ready_o(wready), .cfg_err_o(err)
  );

  function automatic bit b_on(input logic [3:0] m);
    return m inside {4'h1, 4'h2, 4'h3, 4'h6, 4'h7};
  endfunction

  function automatic logic [1:0] b_type(input logic [3:0] m, input logic o);
    case (m)
      4'h1: return 2'd1;
      4'h2: return 2'd2;
      4'h3: return o ? 2'd1 : 2'd2;
      4'h6: return 2'd3;
      4'h7: return o ? 2'd1 : 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [NR-1:0] e_cke();
    logic [NR-1:0] v;
    for (int r = 0; r < NR; r++) v[r] = (m_type[r] == 2'd0);
    return v;
  endfunction

  function automatic logic [2*NR-1:0] e_type();
    logic [2*NR-1:0] v;
    for (int r = 0; r < NR; r++) v[2*r +: 2] = m_type[r];
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < NR; r++) begin m_cnt[r] = 0; m_type[r] = 2'd0; end
    m_glob = 0; m_err = 0; p_v = 0; p_glob = 0;
    m_mode = 0; p_mode = 0; m_idle = 0; p_idle = 0;
  endtask

  task automatic model_step();
    bit awake, apply, en, clr, o;
    int nc[NR];
    logic [1:0] nt[NR];
    awake = 1;
    for (int r = 0; r < NR; r++) if (m_type[r] != 0) awake = 0;
    apply = p_v && awake;
    en = b_on(m_mode) && (m_idle != 0);
    for (int r = 0; r < NR; r++) begin
      clr = apply || (m_glob ? (|cmd) : cmd[r]);
      o   = m_glob ? (|open) : open[r];
      nc[r] = m_cnt[r]; nt[r] = m_type[r];
      if (clr) begin nc[r] = 0; nt[r] = 0; end
      else begin
        if (en && m_type[r] == 0 && m_cnt[r] == m_idle - 1) nt[r] = b_type(m_mode, o);
        if (en && m_cnt[r] < m_idle) nc[r] = m_cnt[r] + 1;
      end
    end
    for (int r = 0; r < NR; r++) begin m_cnt[r] = nc[r]; m_type[r] = nt[r]; end
    if (apply) begin
      m_glob = p_glob; m_mode = p_mode; m_idle = p_idle;
      if (p_mode != 0 && !b_on(p_mode)) m_err = 1;
    end
    if (we) begin p_v = 1; p_glob = glob_in; p_mode = mode_in; p_idle = int'(idle_in); end
    else if (apply) p_v = 0;
  endtask

  // one clock: inputs already set; model steps after the edge; outputs sampled on the falling edge
  task automatic cycle();
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
    chk(cke === e_cke(), "R2 cke", int'(cke), int'(e_cke()));
    chk(ptype === e_type(), "R6 pd_type", int'(ptype), int'(e_type()));
    chk(wready === (&e_cke()), "R10 wake_ready", int'(wready), int'(&e_cke()));
    chk(err === m_err, "R8 err flag", int'(err), int'(m_err));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  // wake all, write config, then the apply edge; counters start from zero
  task automatic set_cfg(input logic g, input logic [3:0] m, input int idl);
    cmd = '1; we = 1; glob_in = g; mode_in = m; idle_in = IW'(idl);
    cycle();
    cmd = '0; we = 0;
    cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int rate;
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cke === '1 && ptype === '0 && wready === 1 && err === 0, "R1 reset state",
        int'({err, wready, ptype, cke}), int'({1'b0, 1'b1, 8'h00, 4'hf}));
    run(10);
    chk(cke === '1, "R1 disabled after reset", int'(cke), 'hf);

    // per-rank APD, threshold 3
    set_cfg(0, 4'h1, 3);
    run(2);
    chk(cke === 4'hf, "R2 still awake after N-1 idle", int'(cke), 'hf);
    run(1);
    chk(cke === 4'h0, "R2 asleep after N idle", int'(cke), 0);
    chk(ptype === 8'b01010101, "R6 active type", int'(ptype), 'h55);

    cmd = 4'b0010; cycle(); cmd = '0;
    chk(cke === 4'b0010, "R3 command wakes only its rank", int'(cke), 'h2);

    // write while ranks asleep: must be held
    we = 1; glob_in = 1; mode_in = 4'h2; idle_in = 8'd2; cycle(); we = 0;
    run(3);
    chk(ptype === 8'b01010101, "R9 config held while asleep", int'(ptype), 'h55);
    cmd = '1; cycle(); cmd = '0;
    cycle(); // apply edge
    run(1);
    chk(cke === 4'hf, "R9 applied, counter restarted", int'(cke), 'hf);
    run(1);
    chk(ptype === 8'b10101010, "R4 global precharge entry", int'(ptype), 'haa);
    cmd = 4'b0100; cycle(); cmd = '0;
    chk(cke === 4'hf, "R4 one command wakes all ranks", int'(cke), 'hf);

    // combined modes, per rank, threshold 1
    open = 4'b0101;
    set_cfg(0, 4'h3, 1);
    run(1);
    chk(ptype === 8'b10011001, "R7 APD-PPD by page state", int'(ptype), 'h99);
    set_cfg(0, 4'h7, 1);
    run(1);
    chk(ptype === 8'b11011101, "R7 APD-DLL by page state", int'(ptype), 'hdd);
    open = 4'b0000; run(3);
    chk(ptype === 8'b11011101, "R7 type held while asleep", int'(ptype), 'hdd);
    set_cfg(1, 4'h7, 1); open = 4'b1000;
    run(1);
    chk(ptype === 8'b01010101, "R4 global page-open uses any rank", int'(ptype), 'h55);
    open = '0;
    set_cfg(0, 4'h6, 2);
    run(2);
    chk(ptype === 8'b11111111, "R6 DLL-off type", int'(ptype), 'hff);

    set_cfg(0, 4'h0, 5); run(20);
    chk(cke === 4'hf, "R5 mode 0 never sleeps", int'(cke), 'hf);
    set_cfg(0, 4'h1, 0); run(20);
    chk(cke === 4'hf, "R5 threshold 0 never sleeps", int'(cke), 'hf);

    set_cfg(0, 4'h4, 2); run(20);
    chk(err === 1 && cke === 4'hf, "R8 reserved mode", int'({err, cke}), 'h1f);
    set_cfg(0, 4'h1, 2); run(5);
    chk(err === 1, "R8 error sticky", int'(err), 1);

    // constrained random
    rate = 10;
    for (int i = 0; i < 6000; i++) begin
      if (i % 250 == 0) begin
        case ($urandom % 4) 0: rate = 0; 1: rate = 3; 2: rate = 15; default: rate = 50; endcase
      end
      for (int r = 0; r < NR; r++) cmd[r] = (($urandom % 100) < rate);
      if ($urandom % 20 == 0) open = NR'($urandom);
      we = ($urandom % 60 == 0);
      if (we) begin
        glob_in = 1'($urandom);
        mode_in = ($urandom % 5 == 0) ? 4'($urandom) :
                  (($urandom % 2) ? 4'h3 : 4'h7);
        idle_in = IW'($urandom % 7);
      end
      cycle();
    end
    cmd = '0; we = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule